// File: doc/BRIEF.md
# Timer Control Register Access Checker

This block judges one coprocessor-style system register access aimed at either of two timer control registers: the hypervisor's physical timer control and the ordinary physical timer control. Its inputs are the instruction's encoding fields, the current privilege level (0 to 3), the non-secure state bit, whether the top (monitor) level is present, whether the hypervisor level is enabled, and three enable or trap bits taken from the kernel and hypervisor timer control registers. The system it serves runs the 32-bit execution state at every level.

The block is purely combinational. For every encoding it gives exactly one outcome: no match, grant, undefined instruction, or trap to the hypervisor with a syndrome code. For a granted access it also says whether the secure or the non-secure copy of the register is the one to use. The read or write direction of the access is an input, but it never changes the result. The decode stage of the core uses the outcome to raise the exception or to steer the access to a register copy.

Top module: `tmr_ctl_access_check`

## Requirements
- R1: An access matches only when coproc = 15, CRn = 14, CRm = 2 and opc2 = 1. opc1 = 4 then selects the hypervisor timer register and opc1 = 0 the physical timer register. Any other encoding drives no_match = 1 and grant, undef, hyp_trap, bank_secure and trap_code all to 0.
- R2: Exactly one of no_match, grant, undef and hyp_trap is 1 for every input. Changing acc_write changes no output.
- R3: Hypervisor timer register at level 0 or level 1: undef.
- R4: Hypervisor timer register at level 2: grant. At level 3: grant when nonsecure = 1 and undef when nonsecure = 0. bank_secure is 0 for this register.
- R5: Physical timer register at level 3: grant, with bank_secure = 1 when nonsecure = 0 and bank_secure = 0 when nonsecure = 1.
- R6: Physical timer register at level 1: when hyp_enabled = 1 and hyp_pl1_cnt_en = 0, hyp_trap with trap_code 0x03. In every other case, grant with bank_secure = 0.
- R7: Physical timer register at level 2: grant with bank_secure = 0, whatever the enable bits are.
- R8: Physical timer register at level 0 with kern_pl0_tmr_en = 0: hyp_trap with trap_code 0x00 when hyp_enabled = 1 and hyp_trap_gen = 1. In every other case, undef.
- R9: Physical timer register at level 0 with kern_pl0_tmr_en = 1: when hyp_enabled = 1 and hyp_pl1_cnt_en = 0, hyp_trap with trap_code 0x03. In every other case, grant with bank_secure = top_present AND NOT nonsecure.
- R10: trap_code is 0 whenever hyp_trap is 0, and bank_secure is 0 whenever grant is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_coproc | input | 4 | Coprocessor number of the access |
| acc_opc1 | input | 3 | First opcode field; picks the register |
| acc_crn | input | 4 | Primary register number field |
| acc_crm | input | 4 | Secondary register number field |
| acc_opc2 | input | 3 | Second opcode field |
| acc_write | input | 1 | 1 for a write, 0 for a read; has no effect on the outputs |
| cur_level | input | 2 | Current privilege level, 0 to 3 |
| nonsecure | input | 1 | Non-secure state bit |
| top_present | input | 1 | The monitor level is implemented |
| hyp_enabled | input | 1 | The hypervisor level is enabled for the current state |
| kern_pl0_tmr_en | input | 1 | Kernel bit that lets level 0 reach the physical timer |
| hyp_pl1_cnt_en | input | 1 | Hypervisor bit that lets levels 0 and 1 reach the physical timer |
| hyp_trap_gen | input | 1 | Hypervisor bit that routes general level-0 exceptions to the hypervisor |
| no_match | output | 1 | The encoding names neither timer register |
| grant | output | 1 | The access is permitted |
| undef | output | 1 | The access is an undefined instruction |
| hyp_trap | output | 1 | The access traps to the hypervisor |
| trap_code | output | SYN_W | Syndrome code of the trap |
| bank_secure | output | 1 | A granted access uses the secure register copy |

## Verification
The block holds no state, so every fault shows at the ports as soon as the inputs settle. A wrong priority between the kernel check and the hypervisor check appears as a trap in place of an undefined instruction, or as the wrong one of the two syndrome codes, at level 0. Bank selection errors show only on granted accesses, so the checks cross the non-secure bit, the privilege level and the presence of the monitor level with permitted accesses. The hypervisor register's rules differ sharply from the physical timer's, so the bench also checks that a one-bit slip in opc1 lands on no_match.

// File: rtl/tmr_ctl_access_check.sv
module tmr_ctl_access_check #(
  parameter int SYN_W = 8
) (
  input  logic [3:0]       acc_coproc,
  input  logic [2:0]       acc_opc1,
  input  logic [3:0]       acc_crn,
  input  logic [3:0]       acc_crm,
  input  logic [2:0]       acc_opc2,
  input  logic             acc_write,
  input  logic [1:0]       cur_level,
  input  logic             nonsecure,
  input  logic             top_present,
  input  logic             hyp_enabled,
  input  logic             kern_pl0_tmr_en,
  input  logic             hyp_pl1_cnt_en,
  input  logic             hyp_trap_gen,
  output logic             no_match,
  output logic             grant,
  output logic             undef,
  output logic             hyp_trap,
  output logic [SYN_W-1:0] trap_code,
  output logic             bank_secure
);

  localparam logic [SYN_W-1:0] CODE_GEN = SYN_W'(0);
  localparam logic [SYN_W-1:0] CODE_TMR = SYN_W'(3);

  logic base_hit, sel_hyp, sel_phys;
  logic ph_grant, ph_undef, ph_trap, ph_secure;
  logic hy_grant;
  logic [SYN_W-1:0] ph_code;
  logic cnt_block;

  assign base_hit = (acc_coproc == 4'd15) && (acc_crn == 4'd14) &&
                    (acc_crm == 4'd2) && (acc_opc2 == 3'd1);
  assign sel_hyp  = base_hit && (acc_opc1 == 3'd4);
  assign sel_phys = base_hit && (acc_opc1 == 3'd0);

  assign hy_grant  = cur_level[1] && (!cur_level[0] || nonsecure);
  assign cnt_block = hyp_enabled && !hyp_pl1_cnt_en;

  always_comb begin
    ph_grant  = 1'b0;
    ph_undef  = 1'b0;
    ph_trap   = 1'b0;
    ph_secure = 1'b0;
    ph_code   = '0;
    unique case (cur_level)
      2'd0: begin
        if (!kern_pl0_tmr_en) begin
          if (hyp_enabled && hyp_trap_gen) begin
            ph_trap = 1'b1;
            ph_code = CODE_GEN;
          end else begin
            ph_undef = 1'b1;
          end
        end else if (cnt_block) begin
          ph_trap = 1'b1;
          ph_code = CODE_TMR;
        end else begin
          ph_grant  = 1'b1;
          ph_secure = top_present && !nonsecure;
        end
      end
      2'd1: begin
        if (cnt_block) begin
          ph_trap = 1'b1;
          ph_code = CODE_TMR;
        end else begin
          ph_grant = 1'b1;
        end
      end
      2'd2: ph_grant = 1'b1;
      default: begin
        ph_grant  = 1'b1;
        ph_secure = !nonsecure;
      end
    endcase
  end

  assign no_match    = !(sel_hyp || sel_phys);
  assign grant       = (sel_hyp && hy_grant) || (sel_phys && ph_grant);
  assign undef       = (sel_hyp && !hy_grant) || (sel_phys && ph_undef);
  assign hyp_trap    = sel_phys && ph_trap;
  assign trap_code   = sel_phys ? ph_code : '0;
  assign bank_secure = sel_phys && ph_secure;

  logic unused_dir;
  assign unused_dir = acc_write;

endmodule

module tmr_ctl_access_check_props #(
  parameter int SYN_W = 8
) (
  input logic [3:0]       acc_coproc,
  input logic [2:0]       acc_opc1,
  input logic [3:0]       acc_crn,
  input logic [3:0]       acc_crm,
  input logic [2:0]       acc_opc2,
  input logic [1:0]       cur_level,
  input logic             nonsecure,
  input logic             no_match,
  input logic             grant,
  input logic             undef,
  input logic             hyp_trap,
  input logic [SYN_W-1:0] trap_code,
  input logic             bank_secure
);

  logic known, hit_hyp;
  assign known = !$isunknown({acc_coproc, acc_opc1, acc_crn, acc_crm, acc_opc2,
                              cur_level, nonsecure, no_match, grant, undef,
                              hyp_trap, trap_code, bank_secure});
  assign hit_hyp = (acc_coproc == 4'd15) && (acc_crn == 4'd14) && (acc_crm == 4'd2) &&
                   (acc_opc2 == 3'd1) && (acc_opc1 == 3'd4);

  always_comb begin
    if (known) begin
      p_onehot_r2: assert ($countones({no_match, grant, undef, hyp_trap}) == 1);
      p_nomatch_quiet_r1: assert (!no_match || (trap_code == '0 && !bank_secure));
      p_hyp_low_undef_r3: assert (!(hit_hyp && !cur_level[1]) || undef);
      p_hyp_no_trap_r4: assert (!hit_hyp || (!hyp_trap && !bank_secure));
      p_secure_bank_r5: assert (!bank_secure || (grant && (cur_level == 2'd0 || (cur_level == 2'd3 && !nonsecure))));
      p_code_idle_r10: assert (hyp_trap || trap_code == '0);
      p_trap_level_r6: assert (!(hyp_trap && cur_level == 2'd1) || trap_code == SYN_W'(3));
      p_no_trap_high_r7: assert (!(hyp_trap && cur_level[1]));
    end
  end

endmodule

bind tmr_ctl_access_check tmr_ctl_access_check_props #(.SYN_W(SYN_W)) u_props (
  .acc_coproc(acc_coproc), .acc_opc1(acc_opc1), .acc_crn(acc_crn), .acc_crm(acc_crm),
  .acc_opc2(acc_opc2), .cur_level(cur_level), .nonsecure(nonsecure),
  .no_match(no_match), .grant(grant), .undef(undef), .hyp_trap(hyp_trap),
  .trap_code(trap_code), .bank_secure(bank_secure)
);

// File: tb/tmr_ctl_access_check_test.sv
`timescale 1ns/1ps
module tmr_ctl_access_check_test;
  localparam int SYN_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] coproc, crn, crm;
  logic [2:0] opc1, opc2;
  logic wr, ns, top, hen, kpl0, hpl1, tge;
  logic [1:0] lvl;
  logic o_nm, o_gr, o_ud, o_tr, o_bs;
  logic [SYN_W-1:0] o_code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  tmr_ctl_access_check #(.SYN_W(SYN_W)) uut (
    .acc_coproc(coproc), .acc_opc1(opc1), .acc_crn(crn), .acc_crm(crm), .acc_opc2(opc2),
    .acc_write(wr), .cur_level(lvl), .nonsecure(ns), .top_present(top),
    .hyp_enabled(hen), .kern_pl0_tmr_en(kpl0), .hyp_pl1_cnt_en(hpl1), .hyp_trap_gen(tge),
    .no_match(o_nm), .grant(o_gr), .undef(o_ud), .hyp_trap(o_tr),
    .trap_code(o_code), .bank_secure(o_bs)
  );

  // packed result: {no_match, grant, undef, trap, bank_secure, code}
  function automatic logic [12:0] model();
    logic nm, g, u, t, b;
    logic [7:0] c;
    nm = 0; g = 0; u = 0; t = 0; b = 0; c = 8'h00;
    if (!(coproc == 15 && crn == 14 && crm == 2 && opc2 == 1 && (opc1 == 4 || opc1 == 0))) nm = 1;
    else if (opc1 == 4) begin
      if (lvl == 2) g = 1;
      else if (lvl == 3 && ns) g = 1;
      else u = 1;
    end else begin
      if (lvl == 3) begin g = 1; b = !ns; end
      else if (lvl == 2) g = 1;
      else if (lvl == 1) begin
        if (hen && !hpl1) begin t = 1; c = 8'h03; end else g = 1;
      end else begin
        if (!kpl0) begin
          if (hen && tge) begin t = 1; c = 8'h00; end else u = 1;
        end else if (hen && !hpl1) begin t = 1; c = 8'h03; end
        else begin g = 1; b = top && !ns; end
      end
    end
    return {nm, g, u, t, b, c};
  endfunction

  function automatic string tag_of();
    if (!(coproc == 15 && crn == 14 && crm == 2 && opc2 == 1 && (opc1 == 4 || opc1 == 0))) return "R1";
    if (opc1 == 4) return (lvl < 2) ? "R3" : "R4";
    case (lvl)
      2'd3: return "R5";
      2'd2: return "R7";
      2'd1: return "R6";
      default: return kpl0 ? "R9" : "R8";
    endcase
  endfunction

  task automatic compare(input string tag);
    logic [12:0] exp, act;
    #1;
    exp = model();
    act = {o_nm, o_gr, o_ud, o_tr, o_bs, o_code};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
    checks++;
    if ($countones(act[12:9]) != 1 || (!o_tr && o_code != 0) || (!o_gr && o_bs)) begin
      fails++;
      $display("FAIL R10/R2 %s: actual %h expected one-hot outcome and quiet fields", tag, act);
    end
  endtask

  task automatic set_acc(input logic [2:0] o1, input logic [1:0] l, input logic n,
                         input logic tp, input logic he, input logic k, input logic h, input logic tg);
    coproc = 15; crn = 14; crm = 2; opc2 = 1; opc1 = o1; wr = 0;
    lvl = l; ns = n; top = tp; hen = he; kpl0 = k; hpl1 = h; tge = tg;
  endtask

  initial begin
    logic [12:0] first;
    coproc = 0; opc1 = 0; crn = 0; crm = 0; opc2 = 0; wr = 0; lvl = 0;
    ns = 0; top = 0; hen = 0; kpl0 = 0; hpl1 = 0; tge = 0;
    compare("R1 all-zero inputs");
    set_acc(3'd4, 2'd0, 1, 1, 1, 1, 1, 1); compare("R3 hyp reg level 0");
    set_acc(3'd4, 2'd1, 1, 1, 1, 1, 1, 1); compare("R3 hyp reg level 1");
    set_acc(3'd4, 2'd2, 0, 1, 1, 0, 0, 0); compare("R4 hyp reg level 2");
    set_acc(3'd4, 2'd3, 0, 1, 1, 1, 1, 0); compare("R4 hyp reg level 3 secure");
    set_acc(3'd4, 2'd3, 1, 1, 1, 1, 1, 0); compare("R4 hyp reg level 3 nonsecure");
    set_acc(3'd0, 2'd3, 0, 1, 0, 0, 0, 0); compare("R5 phys level 3 secure bank");
    set_acc(3'd0, 2'd3, 1, 1, 0, 0, 0, 0); compare("R5 phys level 3 nonsecure bank");
    set_acc(3'd0, 2'd1, 1, 1, 1, 1, 0, 0); compare("R6 phys level 1 counter trap");
    set_acc(3'd0, 2'd1, 1, 1, 0, 1, 0, 0); compare("R6 phys level 1 hyp off");
    set_acc(3'd0, 2'd2, 1, 1, 1, 0, 0, 0); compare("R7 phys level 2");
    set_acc(3'd0, 2'd0, 1, 1, 1, 0, 0, 1); compare("R8 level 0 general trap");
    set_acc(3'd0, 2'd0, 1, 1, 1, 0, 0, 0); compare("R8 level 0 undef tge clear");
    set_acc(3'd0, 2'd0, 1, 1, 0, 0, 1, 1); compare("R8 level 0 undef hyp off");
    set_acc(3'd0, 2'd0, 1, 1, 1, 1, 0, 1); compare("R9 level 0 counter trap");
    set_acc(3'd0, 2'd0, 0, 1, 1, 1, 1, 0); compare("R9 level 0 secure bank");
    set_acc(3'd0, 2'd0, 0, 0, 1, 1, 1, 0); compare("R9 level 0 no monitor");
    set_acc(3'd5, 2'd2, 1, 1, 1, 1, 1, 1); compare("R1 opc1 5");
    set_acc(3'd4, 2'd2, 1, 1, 1, 1, 1, 1); crm = 3; compare("R1 crm off by one");
    set_acc(3'd0, 2'd2, 1, 1, 1, 1, 1, 1); coproc = 14; compare("R1 coproc 14");

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 8;
      coproc = (r == 0) ? 4'($urandom) : 4'd15;
      crn    = (r == 1) ? 4'($urandom) : 4'd14;
      crm    = (r == 2) ? 4'($urandom) : 4'd2;
      opc2   = (r == 3) ? 3'($urandom) : 3'd1;
      opc1   = (r == 4) ? 3'($urandom) : (($urandom % 2) ? 3'd4 : 3'd0);
      lvl = 2'($urandom); ns = 1'($urandom); top = 1'($urandom); hen = 1'($urandom);
      kpl0 = 1'($urandom); hpl1 = 1'($urandom); tge = 1'($urandom);
      wr = 0;
      compare(tag_of());
      first = {o_nm, o_gr, o_ud, o_tr, o_bs, o_code};
      wr = 1;
      #1;
      checks++;
      if ({o_nm, o_gr, o_ud, o_tr, o_bs, o_code} !== first) begin
        fails++;
        $display("FAIL R2 direction: actual %h expected %h", {o_nm, o_gr, o_ud, o_tr, o_bs, o_code}, first);
      end
      @(posedge clk);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule